// File: doc/BRIEF.md
# PRBS Bit Error Rate Tester

A serial test-pattern engine with a transmitter and a receiver. The transmitter emits a pseudo-random bit stream from a linear feedback shift register. A mode input picks one of two maximal-length polynomials. Every run starts from an all-ones seed, and that seed goes out on the line as the first bits of the run. The receiver hunts the incoming line for that run of ones. When it finds the run, it raises a lock flag and loads its own reference generator from the bits it has just received. From then on the reference runs free and predicts each incoming bit, and every bit that differs from the prediction adds one to a saturating error count.

Four level inputs control the block, and each acts on its rising edge: transmit start, generator reseed, receive start and count clear. Each side advances by one bit in every cycle in which the shared bit-enable strobe is high. In normal use the transmit output feeds some path under test and that path's output returns to the receive input. Software reseeds the generator, clears the count, starts both sides, waits for lock and then reads the error count.

Top module: `prbs_bert`

## Requirements
- R1: While reset is asserted and right after it, `lock_o` is 0, `err_cnt_o` is 0 and `tx_bit_o` is 0.
- R2: The transmitter runs only after a rising edge of `tx_start_i`. The first bit appears in the cycle after the edge, and the generator then advances one bit per cycle with `bit_en_i` high. One cycle after `tx_start_i` goes low, `tx_bit_o` is 0 and stays 0. While `bit_en_i` is low, `tx_bit_o` holds its value.
- R3: A rising edge of `gen_reset_i` loads the all-ones seed. The next N transmitted bits are then all 1 (N = 15 when `mode_i` = 0, N = 23 when `mode_i` = 1).
- R4: After the seed, each transmitted bit u[m] follows u[m] = u[m-15] ^ u[m-14] when `mode_i` = 0 (x^15+x^14+1). It follows u[m] = u[m-23] ^ u[m-18] when `mode_i` = 1 (x^23+x^18+1).
- R5: A rising edge of `rx_start_i` clears `lock_o` and restarts the hunt with an empty history. `lock_o` rises in the cycle after the Nth consecutive received 1 of the mode's length, and not earlier.
- R6: Once locked, each received bit that differs from the reference prediction raises `err_cnt_o` by exactly one, one cycle later. The count never rises by more than one per cycle and holds while `bit_en_i` is low.
- R7: While `rx_start_i` is low, comparison stops and `err_cnt_o` holds its value. A falling edge of `rx_start_i` leaves `lock_o` unchanged.
- R8: A rising edge of `clr_cnt_i` sets `err_cnt_o` to 0. Holding `clr_cnt_i` high has no further effect, so counting resumes.
- R9: `err_cnt_o` (16 bits) saturates at 65535 and does not wrap.
- R10: A receive stream without N consecutive ones, such as all zeros, never raises `lock_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0: 2^15-1 sequence, 1: 2^23-1 sequence |
| bit_en_i | input | 1 | Bit strobe; both sides advance when high |
| tx_start_i | input | 1 | Rising edge starts transmission; low disables it |
| gen_reset_i | input | 1 | Rising edge loads the seed into the transmit generator |
| rx_start_i | input | 1 | Rising edge starts the seed hunt; low freezes checking |
| clr_cnt_i | input | 1 | Rising edge clears the error count |
| rx_bit_i | input | 1 | Serial data under test |
| tx_bit_o | output | 1 | Serial PRBS output |
| lock_o | output | 1 | Receiver has found the seed |
| err_cnt_o | output | 16 | Saturating bit error count |

## Verification
The bench loops the transmit output back to the receive input through an XOR that it drives, and it checks every transmitted bit against its own recurrence for each polynomial. A clean loop must leave the count at zero in both modes. That proves the transmitter and the reference agree on taps and phase. Errors are injected at periods of 10, 7 and every bit. Because the reference runs free after lock, each flipped bit must add exactly one, which tells this design apart from one that resynchronises on the input. An all-zero stream must never lock. A continuous inversion long enough to pass 65535 errors checks that the count stops at its maximum and does not wrap.

// File: rtl/prbs_bert_pkg.sv
package prbs_bert_pkg;

  localparam int unsigned SHORT_LEN = 15;
  localparam int unsigned SHORT_TAP = 14;
  localparam int unsigned LONG_LEN  = 23;
  localparam int unsigned LONG_TAP  = 18;
  localparam int unsigned STATE_W   = LONG_LEN;

  typedef enum logic {SEQ_SHORT = 1'b0, SEQ_LONG = 1'b1} seq_mode_e;
  typedef logic [STATE_W-1:0] prbs_state_t;

  localparam prbs_state_t SEED = '1;

  function automatic logic prbs_feedback(prbs_state_t s, seq_mode_e m);
    return (m == SEQ_LONG) ? (s[LONG_LEN-1] ^ s[LONG_TAP-1])
                           : (s[SHORT_LEN-1] ^ s[SHORT_TAP-1]);
  endfunction

  // oldest bit of the window is the next one on the line
  function automatic logic prbs_oldest(prbs_state_t s, seq_mode_e m);
    return (m == SEQ_LONG) ? s[LONG_LEN-1] : s[SHORT_LEN-1];
  endfunction

  function automatic prbs_state_t prbs_next(prbs_state_t s, seq_mode_e m);
    return {s[STATE_W-2:0], prbs_feedback(s, m)};
  endfunction

  function automatic prbs_state_t seed_mask(seq_mode_e m);
    return (m == SEQ_LONG) ? SEED
                           : {{(STATE_W-SHORT_LEN){1'b0}}, {SHORT_LEN{1'b1}}};
  endfunction

endpackage

// File: rtl/prbs_bert_rise.sv
module prbs_bert_rise #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_det
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/prbs_bert_gen.sv
module prbs_bert_gen
  import prbs_bert_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  seq_mode_e mode_i,
  input  logic      load_i,
  input  logic      adv_i,
  input  logic      en_i,
  output logic      bit_o
);
  prbs_state_t state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (load_i) state_q <= SEED;
    else if (adv_i)  state_q <= prbs_next(state_q, mode_i);
  end

  assign bit_o = en_i & prbs_oldest(state_q, mode_i);
endmodule

// File: rtl/prbs_bert_rx.sv
module prbs_bert_rx
  import prbs_bert_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  seq_mode_e        mode_i,
  input  logic             restart_i,
  input  logic             go_i,
  input  logic             clear_i,
  input  logic             bit_i,
  output logic             lock_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  prbs_state_t win_q, ref_q, win_n;
  logic        lock_q, seed_hit, expect_bit, miss;
  logic [CNT_W-1:0] cnt_q;

  assign win_n      = {win_q[STATE_W-2:0], bit_i};
  assign seed_hit   = (win_n & seed_mask(mode_i)) == seed_mask(mode_i);
  assign expect_bit = prbs_feedback(ref_q, mode_i);
  assign miss       = go_i & lock_q & (bit_i ^ expect_bit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      win_q  <= '0;
      ref_q  <= '0;
    end else if (restart_i) begin
      lock_q <= 1'b0;
      win_q  <= '0;
    end else if (go_i) begin
      if (!lock_q) begin
        win_q <= win_n;
        if (seed_hit) begin
          lock_q <= 1'b1;
          ref_q  <= win_n;
        end
      end else begin
        // reference runs free: a line error never enters it
        ref_q <= {ref_q[STATE_W-2:0], expect_bit};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clear_i)                 cnt_q <= '0;
    else if (miss && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign lock_o = lock_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/prbs_bert.sv
module prbs_bert
  import prbs_bert_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             bit_en_i,
  input  logic             tx_start_i,
  input  logic             gen_reset_i,
  input  logic             rx_start_i,
  input  logic             clr_cnt_i,
  input  logic             rx_bit_i,
  output logic             tx_bit_o,
  output logic             lock_o,
  output logic [CNT_W-1:0] err_cnt_o
);
  localparam int unsigned NCTL    = 4;
  localparam int unsigned CTL_TX  = 0;
  localparam int unsigned CTL_GEN = 1;
  localparam int unsigned CTL_RX  = 2;
  localparam int unsigned CTL_CLR = 3;

  seq_mode_e       mode;
  logic [NCTL-1:0] ctl_lvl, ctl_rise;
  logic            tx_rise, gen_rise, rx_rise, clr_rise;
  logic            tx_en_q, rx_en_q, tx_adv, rx_go;

  assign mode = seq_mode_e'(mode_i);

  assign ctl_lvl[CTL_TX]  = tx_start_i;
  assign ctl_lvl[CTL_GEN] = gen_reset_i;
  assign ctl_lvl[CTL_RX]  = rx_start_i;
  assign ctl_lvl[CTL_CLR] = clr_cnt_i;

  prbs_bert_rise #(.N(NCTL)) u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (ctl_lvl),
    .rise_o (ctl_rise)
  );

  assign tx_rise  = ctl_rise[CTL_TX];
  assign gen_rise = ctl_rise[CTL_GEN];
  assign rx_rise  = ctl_rise[CTL_RX];
  assign clr_rise = ctl_rise[CTL_CLR];

  // armed by an edge, dropped as soon as the level falls
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
    end else begin
      tx_en_q <= tx_rise | (tx_start_i & tx_en_q);
      rx_en_q <= rx_rise | (rx_start_i & rx_en_q);
    end
  end

  assign tx_adv = tx_en_q & tx_start_i & bit_en_i;
  assign rx_go  = rx_en_q & rx_start_i & bit_en_i;

  prbs_bert_gen u_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .load_i (gen_rise),
    .adv_i  (tx_adv),
    .en_i   (tx_en_q),
    .bit_o  (tx_bit_o)
  );

  prbs_bert_rx #(.CNT_W(CNT_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .restart_i (rx_rise),
    .go_i      (rx_go),
    .clear_i   (clr_rise),
    .bit_i     (rx_bit_i),
    .lock_o    (lock_o),
    .cnt_o     (err_cnt_o)
  );
endmodule

// File: rtl/prbs_bert_chk.sv
module prbs_bert_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_en_i,
  input logic             tx_start_i,
  input logic             rx_start_i,
  input logic             tx_bit_o,
  input logic             lock_o,
  input logic [CNT_W-1:0] err_cnt_o,
  input logic             rx_rise,
  input logic             clr_rise
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  assert_tx_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_start_i |=> !tx_bit_o);

  assert_lock_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> $past(rx_rise));

  assert_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (err_cnt_o == '0) || (err_cnt_o == $past(err_cnt_o))
             || (err_cnt_o == $past(err_cnt_o) + CNT_ONE));

  assert_hold_bit_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_en_i && !clr_rise) |=> $stable(err_cnt_o));

  assert_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_start_i && !clr_rise) |=> $stable(err_cnt_o));

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_rise |=> err_cnt_o == '0);

  assert_no_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o == CNT_MAX && !clr_rise) |=> err_cnt_o == CNT_MAX);
endmodule

bind prbs_bert prbs_bert_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_en_i   (bit_en_i),
  .tx_start_i (tx_start_i),
  .rx_start_i (rx_start_i),
  .tx_bit_o   (tx_bit_o),
  .lock_o     (lock_o),
  .err_cnt_o  (err_cnt_o),
  .rx_rise    (rx_rise),
  .clr_rise   (clr_rise)
);

// File: tb/prbs_bert_tb_top.sv
module prbs_bert_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni, mode_i, bit_en_i, tx_start_i, gen_reset_i;
  logic        rx_start_i, clr_cnt_i, flip, tx_bit_o, lock_o, rx_bit_i;
  logic [15:0] err_cnt_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic u [0:1023];

  typedef struct packed {
    logic        mode;
    logic [15:0] len;
    logic [15:0] period;
    logic [15:0] exp_errs;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [0:NVEC-1] = '{
    '{1'b0, 16'd200, 16'd0,  16'd0},
    '{1'b1, 16'd300, 16'd0,  16'd0},
    '{1'b0, 16'd100, 16'd10, 16'd10},
    '{1'b1, 16'd99,  16'd7,  16'd15},
    '{1'b1, 16'd50,  16'd1,  16'd50}
  };

  always #5 clk_i = ~clk_i;

  assign rx_bit_i = tx_bit_o ^ flip;

  prbs_bert dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .bit_en_i    (bit_en_i),
    .tx_start_i  (tx_start_i),
    .gen_reset_i (gen_reset_i),
    .rx_start_i  (rx_start_i),
    .clr_cnt_i   (clr_cnt_i),
    .rx_bit_i    (rx_bit_i),
    .tx_bit_o    (tx_bit_o),
    .lock_o      (lock_o),
    .err_cnt_o   (err_cnt_o)
  );

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  endtask

  // bench model of the line: seed ones then the chosen recurrence
  task automatic model_bit(input int j, input logic m, output logic b);
    int n;
    n = m ? 23 : 15;
    if (j < n) u[j] = 1'b1;
    else       u[j] = m ? (u[j-23] ^ u[j-18]) : (u[j-15] ^ u[j-14]);
    b = u[j];
  endtask

  task automatic start_both(input logic m);
    tx_start_i = 0; rx_start_i = 0; flip = 0; bit_en_i = 1; mode_i = m;
    step();
    gen_reset_i = 1; clr_cnt_i = 1;
    step();
    gen_reset_i = 0; clr_cnt_i = 0;
    tx_start_i = 1; rx_start_i = 1;
    step();
  endtask

  task automatic run_vec(input vec_t v);
    int   n, j, txbad;
    logic b;
    n = v.mode ? 23 : 15;
    j = 0; txbad = 0;
    start_both(v.mode);
    for (int k = 0; k < n; k++) begin
      model_bit(j, v.mode, b);
      if (tx_bit_o !== b) txbad++;
      if (k == n - 1) chk("R5 no lock before seed complete", lock_o, 0);
      step(); j++;
    end
    chk("R5 lock after seed", lock_o, 1);
    for (int i = 0; i < int'(v.len); i++) begin
      flip = (v.period != 0) && (i % int'(v.period) == 0);
      model_bit(j, v.mode, b);
      if (tx_bit_o !== b) txbad++;
      step(); j++;
    end
    flip = 0;
    chk("R4 transmitted sequence mismatches", txbad, 0);
    chk("R6 error count", err_cnt_o, v.exp_errs);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    summary();
  end

  initial begin
    int   ones;
    logic ok;
    rst_ni = 0; mode_i = 0; bit_en_i = 0; tx_start_i = 0; gen_reset_i = 0;
    rx_start_i = 0; clr_cnt_i = 0; flip = 0;
    #22;
    chk("R1 lock after reset", lock_o, 0);
    chk("R1 count after reset", err_cnt_o, 0);
    chk("R1 tx after reset", tx_bit_o, 0);
    rst_ni = 1;
    step();

    for (int vi = 0; vi < NVEC; vi++) run_vec(VECS[vi]);

    // R7: freeze while receive start low, lock kept
    rx_start_i = 0; flip = 1;
    repeat (10) step();
    flip = 0;
    chk("R7 count frozen", err_cnt_o, 50);
    chk("R7 lock kept on fall", lock_o, 1);

    // R5: rising edge clears lock
    rx_start_i = 1;
    step();
    chk("R5 lock cleared by restart", lock_o, 0);

    // R8: clear level held high does not block counting
    tx_start_i = 0; rx_start_i = 0; mode_i = 1;
    step();
    gen_reset_i = 1; clr_cnt_i = 1;
    step();
    chk("R8 cleared on edge", err_cnt_o, 0);
    gen_reset_i = 0; tx_start_i = 1; rx_start_i = 1;
    step();
    repeat (23) step();
    chk("R5 relock mode 23", lock_o, 1);
    flip = 1; step(); flip = 0; step();
    chk("R8 held clear has no effect", err_cnt_o, 1);
    clr_cnt_i = 0; step();
    clr_cnt_i = 1; step();
    chk("R8 second edge clears", err_cnt_o, 0);
    clr_cnt_i = 0;

    // R3 reseed mid-run, R2 bit enable hold
    gen_reset_i = 1; step(); gen_reset_i = 0;
    ones = 0;
    for (int k = 0; k < 22; k++) begin
      if (tx_bit_o === 1'b1) ones++;
      step();
    end
    chk("R3 seed ones", ones, 22);
    bit_en_i = 0;
    ok = 1'b1;
    for (int k = 0; k < 5; k++) begin
      if (tx_bit_o !== 1'b1) ok = 1'b0;
      step();
    end
    chk("R2 output held while bit_en low", ok, 1);
    bit_en_i = 1;
    step();
    chk("R4 first bit after seed mode 23", tx_bit_o, 0);

    // R2 transmit disabled when start low
    tx_start_i = 0;
    step();
    ok = (tx_bit_o === 1'b0);
    repeat (5) begin
      step();
      if (tx_bit_o !== 1'b0) ok = 1'b0;
    end
    chk("R2 tx off while start low", ok, 1);

    // R10 all-zero input never locks
    rx_start_i = 0; step();
    rx_start_i = 1; step();
    repeat (60) step();
    chk("R10 no lock on zero stream", lock_o, 0);

    // R9 saturation
    start_both(1'b0);
    repeat (15) step();
    chk("R5 lock mode 15 before saturation run", lock_o, 1);
    flip = 1;
    repeat (65540) step();
    flip = 0;
    chk("R9 count saturates", err_cnt_o, 16'hFFFF);

    // R1 reset mid-run
    rst_ni = 0;
    #1;
    chk("R1 lock in reset", lock_o, 0);
    chk("R1 count in reset", err_cnt_o, 0);
    summary();
  end
endmodule